// File: doc/BRIEF.md
# SDRAM Page-Mode Command Controller

This block turns read and write burst requests into SDRAM commands for one chip select. Each request names a bank, a row and a column. The controller keeps a table of the open row in every bank. A request that hits an open row goes straight to the column command. A request that targets a different row in a bank that already has an open row first closes that bank with a single-bank precharge. A request to a closed bank opens the row first. Rows stay open after every burst, because auto-precharge is never used.

The device is set up once after reset. A write to the configuration port captures the CAS latency (1 to 4), the port width and the page-hold option. The configuration then locks, and the controller sends a single MODE-SET carrying the CAS latency, the sequential burst type and the burst length. The burst length is 4 beats on a 64-bit port and 8 beats on a 32-bit port. When the request bus goes idle, open rows are closed with a precharge-all unless page-hold is set. A periodic refresh timer is served ahead of new requests whenever the controller is idle. The timer first precharges all banks if any row is open.

The controller states are WAIT_CFG, MODE_SET, IDLE, PRECH, PRECH_WAIT, ACTIV, ACTIV_WAIT, ACCESS, BURST, REFR and REFR_WAIT. The transitions are:
- WAIT_CFG→MODE_SET once the configuration is written, then MODE_SET→IDLE.
- From IDLE, the first matching case applies, in this priority:
  - Refresh due with open rows: IDLE→PRECH(all).
  - Refresh due with every bank precharged: IDLE→REFR.
  - Row hit: IDLE→ACCESS.
  - Row miss: IDLE→PRECH(single).
  - Closed bank: IDLE→ACTIV.
  - Bus idle with rows open and page-hold clear: IDLE→PRECH(all).
- PRECH→PRECH_WAIT, then PRECH_WAIT→ACTIV, →REFR or →IDLE, depending on why the precharge was issued.
- ACTIV→ACTIV_WAIT→ACCESS.
- ACCESS→BURST→IDLE.
- REFR→REFR_WAIT→IDLE.

Top module: `sdram_page_ctrl`

## Requirements
- R1: A request whose bank already has its requested row open is served without any ACTIVATE. The READ or WRITE follows in the cycle after acceptance.
- R2: With page-hold clear, an idle bus with any row open leads to a PRECHARGE with address bit 10 high, which closes every bank.
- R3: With page-hold set, rows stay open while the bus is idle. No precharge is issued except for a refresh.
- R4: A request to a bank whose open row differs is preceded by a PRECHARGE with address bit 10 low and the bank on the bank pins. An ACTIVATE only ever targets a precharged bank, with the row on the address pins.
- R5: A REFRESH is only issued when all banks are precharged. Open rows are first closed with a precharge-all.
- R6: A REFRESH follows within REF_INTERVAL plus a bounded service delay of the previous REFRESH or MODE-SET. It is served ahead of a waiting request.
- R7: The burst length is 4 beats when cfg_wide=1 (64-bit port) and 8 beats when cfg_wide=0 (32-bit port). wr_beat is high from the WRITE command for exactly that many consecutive cycles.
- R8: Exactly one MODE-SET is sent after the configuration write. Its address bits [2:0] carry the burst code (010 for 4 beats, 011 for 8 beats), bit 3 is 0 (sequential), and bits [6:4] carry the CAS latency.
- R9: rd_valid rises exactly CAS-latency cycles after the READ command and stays high for burst-length consecutive cycles.
- R10: READ and WRITE carry the column on the low address bits, address bit 10 low (no auto-precharge), and the bank of an open row matching the request. The row stays open afterwards.
- R11: ACTIVATE to READ/WRITE is at least T_RCD cycles. PRECHARGE to ACTIVATE is at least T_RP cycles. REFRESH to ACTIVATE is at least T_RFC cycles. Each of these parameters is at least 2.
- R12: Configuration writes after the first one following reset have no effect.
- R13: Before the configuration write, req_ready is low and only NOP is driven. Command encodings on {cs_n,ras_n,cas_n,we_n} are: ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE-SET 0000, NOP 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe, taken once after reset |
| cfg_cas_lat | input | 3 | CAS latency, 1 to 4 |
| cfg_wide | input | 1 | 1: 64-bit port (4 beats), 0: 32-bit port (8 beats) |
| cfg_page_hold | input | 1 | Keep rows open while the bus is idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1: write burst, 0: read burst |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Row, column or mode address; bit 10 selects precharge-all |
| sd_dqm | output | 1 | Data mask, low during data beats |
| rd_valid | output | 1 | Read data beat valid |
| wr_beat | output | 1 | Write data beat expected |

## Verification
The same request sequence is swept over every combination of CAS latency, port width and page-hold. Repeated hits on one row separate R1 from a design that reopens rows. A different row in the same bank, and a fresh bank, separate the single-bank precharge path from a plain activate. An idle gap followed by a hit on an earlier row shows whether page-hold kept that row open or forced a new ACTIVATE. A long stream of back-to-back requests can only ever see a REFRESH if refresh is served ahead of waiting requests. A second, discarded configuration write is caught by the MODE-SET fields and the read-data timing.

// File: rtl/sdram_page_pkg.sv
package sdram_page_pkg;

    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REFR  = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_WAIT_CFG,
        ST_MODE_SET,
        ST_IDLE,
        ST_PRECH,
        ST_PRECH_WAIT,
        ST_ACTIV,
        ST_ACTIV_WAIT,
        ST_ACCESS,
        ST_BURST,
        ST_REFR,
        ST_REFR_WAIT
    } ctl_state_e;

    typedef enum logic [1:0] {
        GOAL_MISS,
        GOAL_REFRESH,
        GOAL_CLOSE
    } pre_goal_e;

    typedef struct packed {
        logic [2:0] cas_lat;
        logic       wide;
        logic       page_hold;
    } sd_cfg_t;

endpackage

// File: rtl/sdram_cfg_reg.sv
module sdram_cfg_reg
    import sdram_page_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] cas_in,
    input  logic       wide_in,
    input  logic       hold_in,
    output sd_cfg_t    cfg_q,
    output logic       done_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else if (wr_en && !done_q) begin
            cfg_q.cas_lat   <= cas_in;
            cfg_q.wide      <= wide_in;
            cfg_q.page_hold <= hold_in;
            done_q          <= 1'b1;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> ($stable(cfg_q) && done_q)); // R12

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic [BA_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic             pre_en,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  pre_bank,
    input  logic [BA_W-1:0]  look_bank,
    input  logic [ROW_W-1:0] look_row,
    output logic             look_open,
    output logic             look_hit,
    output logic             any_open
);

    logic [BANKS-1:0] open_q;
    logic [ROW_W-1:0] row_q [BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int b = 0; b < BANKS; b++) row_q[b] <= '0;
        end else begin
            for (int b = 0; b < BANKS; b++) begin
                if (act_en && act_bank == BA_W'(b)) begin
                    open_q[b] <= 1'b1;
                    row_q[b]  <= act_row;
                end else if (pre_en && (pre_all || pre_bank == BA_W'(b))) begin
                    open_q[b] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        look_open = open_q[look_bank];
        look_hit  = open_q[look_bank] && (row_q[look_bank] == look_row);
        any_open  = |open_q;
    end

    AST_ACT_TO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !open_q[act_bank]); // R4

    AST_PRE_NOT_WITH_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> !act_en); // R11

endmodule

// File: rtl/sdram_rd_window.sv
module sdram_rd_window #(
    parameter int LAT_MAX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [2:0] cas_lat,
    input  logic [3:0] beats,
    output logic       rd_valid
);

    localparam int IDX_W = $clog2(LAT_MAX);

    logic [LAT_MAX-1:0] lat_sh;
    logic [3:0]         left_q;
    logic [IDX_W-1:0]   tap;
    logic               start;

    assign tap   = IDX_W'(cas_lat - 3'd1);
    assign start = lat_sh[tap];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_sh <= '0;
            left_q <= '0;
        end else begin
            lat_sh <= {lat_sh[LAT_MAX-2:0], issue};
            if (start)
                left_q <= beats - 4'd1;
            else if (left_q != 4'd0)
                left_q <= left_q - 4'd1;
        end
    end

    assign rd_valid = start || (left_q != 4'd0);

    AST_RDV_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> rd_valid); // R9

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic pending
);

    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && cnt_q != CW'(INTERVAL))
            cnt_q <= cnt_q + 1'b1;
    end

    assign pending = (cnt_q == CW'(INTERVAL));

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending); // R6

endmodule

// File: rtl/sdram_page_ctrl.sv
module sdram_page_ctrl
    import sdram_page_pkg::*;
#(
    parameter int BANKS        = 4,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 9,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 6,
    parameter int REF_INTERVAL = 780,
    parameter int LAT_MAX      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_cas_lat,
    input  logic                     cfg_wide,
    input  logic                     cfg_page_hold,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    output logic                     sd_cs_n,
    output logic                     sd_ras_n,
    output logic                     sd_cas_n,
    output logic                     sd_we_n,
    output logic [$clog2(BANKS)-1:0] sd_ba,
    output logic [ROW_W-1:0]         sd_addr,
    output logic                     sd_dqm,
    output logic                     rd_valid,
    output logic                     wr_beat
);

    localparam int BA_W   = $clog2(BANKS);
    localparam int ADDR_W = ROW_W;
    localparam int WCNT_W = 8;
    localparam int A10    = 10;

    sd_cfg_t    cfg_q;
    logic       cfg_done;
    ctl_state_e state, state_nxt;
    pre_goal_e  goal_q, goal_nxt;
    logic       all_q, all_nxt;
    logic [WCNT_W-1:0] wcnt, wcnt_nxt;

    logic             lat_write;
    logic [BA_W-1:0]  lat_bank;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;

    logic [BA_W-1:0]  look_bank;
    logic [ROW_W-1:0] look_row;
    logic             look_open, look_hit, any_open;
    logic             ref_pending, accept;
    logic [WCNT_W-1:0] beats_w;
    logic [3:0]       beats4;
    sd_cmd_e          cmd;
    logic [ADDR_W-1:0] addr_c;
    logic [BA_W-1:0]  ba_c;

    sdram_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .cas_in  (cfg_cas_lat),
        .wide_in (cfg_wide),
        .hold_in (cfg_page_hold),
        .cfg_q   (cfg_q),
        .done_q  (cfg_done)
    );

    assign look_bank = (state == ST_IDLE) ? req_bank : lat_bank;
    assign look_row  = (state == ST_IDLE) ? req_row  : lat_row;

    sdram_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (state == ST_ACTIV),
        .act_bank  (lat_bank),
        .act_row   (lat_row),
        .pre_en    (state == ST_PRECH),
        .pre_all   (all_q),
        .pre_bank  (lat_bank),
        .look_bank (look_bank),
        .look_row  (look_row),
        .look_open (look_open),
        .look_hit  (look_hit),
        .any_open  (any_open)
    );

    sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != ST_WAIT_CFG),
        .clear   (state == ST_MODE_SET || state == ST_REFR),
        .pending (ref_pending)
    );

    assign beats4 = cfg_q.wide ? 4'd4 : 4'd8;
    assign beats_w = WCNT_W'(beats4);

    sdram_rd_window #(.LAT_MAX(LAT_MAX)) u_rdwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (state == ST_ACCESS && !lat_write),
        .cas_lat  (cfg_q.cas_lat),
        .beats    (beats4),
        .rd_valid (rd_valid)
    );

    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign accept    = req_valid && req_ready;

    // next-state selection
    always_comb begin
        state_nxt = state;
        goal_nxt  = goal_q;
        all_nxt   = all_q;
        wcnt_nxt  = (wcnt != '0) ? wcnt - 1'b1 : wcnt;
        unique case (state)
            ST_WAIT_CFG: begin
                if (cfg_done) state_nxt = ST_MODE_SET;
            end
            ST_MODE_SET: state_nxt = ST_IDLE;
            ST_IDLE: begin
                if (ref_pending) begin
                    if (any_open) begin
                        state_nxt = ST_PRECH;
                        goal_nxt  = GOAL_REFRESH;
                        all_nxt   = 1'b1;
                    end else begin
                        state_nxt = ST_REFR;
                    end
                end else if (req_valid) begin
                    if (look_hit) begin
                        state_nxt = ST_ACCESS;
                    end else if (look_open) begin
                        state_nxt = ST_PRECH;
                        goal_nxt  = GOAL_MISS;
                        all_nxt   = 1'b0;
                    end else begin
                        state_nxt = ST_ACTIV;
                    end
                end else if (any_open && !cfg_q.page_hold) begin
                    state_nxt = ST_PRECH;
                    goal_nxt  = GOAL_CLOSE;
                    all_nxt   = 1'b1;
                end
            end
            ST_PRECH: begin
                state_nxt = ST_PRECH_WAIT;
                wcnt_nxt  = WCNT_W'(T_RP - 2);
            end
            ST_PRECH_WAIT: begin
                if (wcnt == '0) begin
                    unique case (goal_q)
                        GOAL_MISS:    state_nxt = ST_ACTIV;
                        GOAL_REFRESH: state_nxt = ST_REFR;
                        default:      state_nxt = ST_IDLE;
                    endcase
                end
            end
            ST_ACTIV: begin
                state_nxt = ST_ACTIV_WAIT;
                wcnt_nxt  = WCNT_W'(T_RCD - 2);
            end
            ST_ACTIV_WAIT: begin
                if (wcnt == '0) state_nxt = ST_ACCESS;
            end
            ST_ACCESS: begin
                state_nxt = ST_BURST;
                wcnt_nxt  = lat_write ? (beats_w - WCNT_W'(2))
                                      : (beats_w - WCNT_W'(2) + WCNT_W'(cfg_q.cas_lat));
            end
            ST_BURST: begin
                if (wcnt == '0) state_nxt = ST_IDLE;
            end
            ST_REFR: begin
                state_nxt = ST_REFR_WAIT;
                wcnt_nxt  = WCNT_W'(T_RFC - 2);
            end
            ST_REFR_WAIT: begin
                if (wcnt == '0) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_WAIT_CFG;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_WAIT_CFG;
            goal_q    <= GOAL_CLOSE;
            all_q     <= 1'b0;
            wcnt      <= '0;
            lat_write <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
        end else begin
            state  <= state_nxt;
            goal_q <= goal_nxt;
            all_q  <= all_nxt;
            wcnt   <= wcnt_nxt;
            if (accept) begin
                lat_write <= req_write;
                lat_bank  <= req_bank;
                lat_row   <= req_row;
                lat_col   <= req_col;
            end
        end
    end

    // command outputs
    always_comb begin
        cmd    = CMD_NOP;
        addr_c = '0;
        ba_c   = '0;
        unique case (state)
            ST_MODE_SET: begin
                cmd         = CMD_MODE;
                addr_c[2:0] = cfg_q.wide ? 3'b010 : 3'b011;
                addr_c[3]   = 1'b0;
                addr_c[6:4] = cfg_q.cas_lat;
            end
            ST_PRECH: begin
                cmd         = CMD_PRE;
                addr_c[A10] = all_q;
                ba_c        = all_q ? '0 : lat_bank;
            end
            ST_ACTIV: begin
                cmd    = CMD_ACT;
                addr_c = lat_row;
                ba_c   = lat_bank;
            end
            ST_ACCESS: begin
                cmd                = lat_write ? CMD_WRITE : CMD_READ;
                addr_c[COL_W-1:0]  = lat_col;
                ba_c               = lat_bank;
            end
            ST_REFR: cmd = CMD_REFR;
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_addr = addr_c;
    assign sd_ba   = ba_c;
    assign wr_beat = lat_write && (state == ST_ACCESS || state == ST_BURST);
    assign sd_dqm  = !(wr_beat || rd_valid);

    // checker state: cycles since the last precharge
    logic [7:0] since_pre;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_pre <= 8'hFF;
        else if (state == ST_PRECH)
            since_pre <= 8'd1;
        else if (since_pre != 8'hFF)
            since_pre <= since_pre + 8'd1;
    end

    AST_REF_ALL_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFR) |-> !any_open); // R5

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd == CMD_PRE || cmd == CMD_ACT || cmd == CMD_READ || cmd == CMD_WRITE)); // R1

    AST_TRP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_pre >= 8'(T_RP))); // R11

    AST_QUIET_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (cmd == CMD_NOP && !req_ready)); // R13

endmodule

// File: tb/sdram_page_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_page_ctrl_bench;

    localparam int BANKS = 4;
    localparam int ROW_W = 13;
    localparam int COL_W = 9;
    localparam int T_RCD = 2;
    localparam int T_RP  = 3;
    localparam int T_RFC = 6;
    localparam int REF_I = 700;
    localparam int SLACK = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_cas_lat = 3'd1;
    logic cfg_wide = 1'b0;
    logic cfg_page_hold = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid, wr_beat;
    logic [1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;

    always #2 clk = ~clk;

    sdram_page_ctrl #(
        .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(REF_I), .LAT_MAX(4)
    ) u_sdram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cas_lat(cfg_cas_lat),
        .cfg_wide(cfg_wide), .cfg_page_hold(cfg_page_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .rd_valid(rd_valid), .wr_beat(wr_beat)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model of the device state, built from observed commands
    bit mon_on = 0;
    bit b_open [BANKS];
    int b_row [BANKS];
    int last_pre [BANKS];
    int last_act [BANKS];
    int last_ref, last_tick;
    int mrs_cnt, ref_cnt, preall_cnt, act_cnt;
    int rd_start, wr_start;
    int cl, bl;
    bit hold;
    bit cur_v, cur_write, cur_hit;
    int cur_bank, cur_row, cur_col;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            logic [3:0] c;
            int ba;
            int opens;
            c  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            ba = int'(sd_ba);
            case (c)
                4'b0000: begin
                    chk(mrs_cnt == 0, "R8", mrs_cnt, 0);
                    chk(sd_addr[6:4] == 3'(cl), "R8", int'(sd_addr[6:4]), cl);
                    chk(sd_addr[3] == 1'b0, "R8", int'(sd_addr[3]), 0);
                    chk(sd_addr[2:0] == ((bl == 4) ? 3'b010 : 3'b011), "R7",
                        int'(sd_addr[2:0]), (bl == 4) ? 2 : 3);
                    mrs_cnt++;
                    last_tick = cyc;
                end
                4'b0011: begin
                    chk(!b_open[ba], "R4", int'(b_open[ba]), 0);
                    chk(cyc - last_pre[ba] >= T_RP, "R11", cyc - last_pre[ba], T_RP);
                    chk(cyc - last_ref >= T_RFC, "R11", cyc - last_ref, T_RFC);
                    chk(cur_v && !cur_hit, "R1", int'(cur_hit), 0);
                    chk(ba == cur_bank && int'(sd_addr) == cur_row, "R4", int'(sd_addr), cur_row);
                    b_open[ba] = 1;
                    b_row[ba]  = int'(sd_addr);
                    last_act[ba] = cyc;
                    act_cnt++;
                end
                4'b0010: begin
                    if (sd_addr[10]) begin
                        for (int b = 0; b < BANKS; b++) begin
                            b_open[b] = 0;
                            last_pre[b] = cyc;
                        end
                        preall_cnt++;
                    end else begin
                        chk(cur_v && ba == cur_bank && b_open[ba] && b_row[ba] != cur_row,
                            "R4", ba, cur_bank);
                        b_open[ba] = 0;
                        last_pre[ba] = cyc;
                    end
                end
                4'b0001: begin
                    opens = 0;
                    for (int b = 0; b < BANKS; b++) opens += int'(b_open[b]);
                    chk(opens == 0, "R5", opens, 0);
                    chk(cyc - last_tick <= REF_I + SLACK, "R6", cyc - last_tick, REF_I + SLACK);
                    ref_cnt++;
                    last_ref  = cyc;
                    last_tick = cyc;
                end
                4'b0100, 4'b0101: begin
                    chk(cur_v, "R10", int'(cur_v), 1);
                    chk(cur_write == (c == 4'b0100), "R10", int'(c), cur_write ? 4 : 5);
                    chk(ba == cur_bank && b_open[ba] && b_row[ba] == cur_row, "R10", b_row[ba], cur_row);
                    chk(int'(sd_addr[COL_W-1:0]) == cur_col, "R10", int'(sd_addr[COL_W-1:0]), cur_col);
                    chk(sd_addr[10] == 1'b0, "R10", int'(sd_addr[10]), 0);
                    chk(cyc - last_act[ba] >= T_RCD, "R11", cyc - last_act[ba], T_RCD);
                    if (c == 4'b0101) rd_start = cyc + cl;
                    else wr_start = cyc;
                    cur_v = 0;
                end
                4'b0111: ;
                default: chk(0, "R13", int'(c), 7);
            endcase
            chk(rd_valid == (cyc >= rd_start && cyc < rd_start + bl), "R9",
                int'(rd_valid), int'(cyc >= rd_start && cyc < rd_start + bl));
            chk(wr_beat == (cyc >= wr_start && cyc < wr_start + bl), "R7",
                int'(wr_beat), int'(cyc >= wr_start && cyc < wr_start + bl));
        end
    end

    task automatic do_req(input bit w, input int bank, input int row, input int col);
        req_write = w;
        req_bank  = 2'(bank);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        cur_write = w;
        cur_bank  = bank;
        cur_row   = row;
        cur_col   = col;
        cur_hit   = b_open[bank] && b_row[bank] == row;
        cur_v     = 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int count_open();
        int n = 0;
        for (int b = 0; b < BANKS; b++) n += int'(b_open[b]);
        return n;
    endfunction

    task automatic run_cfg(input int lat, input bit wide, input bit hld);
        int t0, acts, pres, refs0;
        cl = lat; bl = wide ? 4 : 8; hold = hld;
        mon_on = 0;
        rst_n  = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            b_open[b] = 0; b_row[b] = 0; last_pre[b] = -1000; last_act[b] = -1000;
        end
        last_ref = -1000; last_tick = cyc;
        mrs_cnt = 0; ref_cnt = 0; preall_cnt = 0; act_cnt = 0;
        rd_start = -1000; wr_start = -1000; cur_v = 0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1;
        // R13: requests are refused before configuration
        req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!req_ready, "R13", int'(req_ready), 0);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R13",
                int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        end
        req_valid = 1'b0;
        cfg_cas_lat = 3'(lat); cfg_wide = wide; cfg_page_hold = hld; cfg_we = 1'b1;
        @(negedge clk);
        // R12: a second write with other values must be discarded
        cfg_cas_lat = 3'((lat % 4) + 1); cfg_wide = !wide; cfg_page_hold = !hld;
        @(negedge clk);
        cfg_we = 1'b0;
        while (mrs_cnt == 0) @(negedge clk);
        chk(mrs_cnt == 1, "R8", mrs_cnt, 1);

        // hits, misses and fresh banks
        do_req(0, 0, 5, 3);
        do_req(0, 0, 5, 7);                   // R1 hit
        do_req(1, 0, 5, 1);                   // R1 hit, write
        do_req(1, 0, 9, 2);                   // R4 miss
        do_req(0, 1, 9, 4);
        do_req(0, 0, 9, 6);                   // R1 hit after miss
        do_req(1, 2, (1 << ROW_W) - 1, (1 << COL_W) - 1);
        do_req(0, 3, 1, 0);
        pres = preall_cnt;
        repeat (40) @(negedge clk);
        if (hld) begin
            chk(count_open() == 4, "R3", count_open(), 4);
            chk(preall_cnt == pres, "R3", preall_cnt, pres);
        end else begin
            chk(count_open() == 0, "R2", count_open(), 0);
            chk(preall_cnt == pres + 1, "R2", preall_cnt, pres + 1);
        end
        acts = act_cnt;
        do_req(0, 1, 9, 8);
        repeat (40) @(negedge clk);
        chk(act_cnt - acts == (hld ? 0 : 1), "R1", act_cnt - acts, hld ? 0 : 1);

        // back-to-back stream: refresh only happens if it outranks requests
        refs0 = ref_cnt;
        t0 = cyc;
        for (int k = 0; cyc < t0 + REF_I + 60; k++)
            do_req(k[0], k % 4, (k / 4) % 3, k % 16);
        repeat (40) @(negedge clk);
        chk(ref_cnt > refs0, "R6", ref_cnt - refs0, 1);
        chk(mrs_cnt == 1, "R8", mrs_cnt, 1);
    endtask

    initial begin
        @(negedge clk);
        for (int lat = 1; lat <= 4; lat++)
            for (int w = 0; w < 2; w++)
                for (int h = 0; h < 2; h++)
                    run_cfg(lat, w[0], h[0]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule